// File: doc/BRIEF.md
# Two-Level Address Translation Buffer with Region-Wide First Level

The block turns a virtual page number into a physical page number using two translation caches of very different shape. The first level is a small fully-associative array whose entries each stand for a large aligned region of consecutive 4 KB pages. Each entry holds its own valid bit and physical page number for every page in that region. The second level is a set-associative array that holds one 4 KB page per way.

A lookup that misses both levels raises a request to a single-level page-table stand-in outside the block. The stand-in answers with the physical page number, and the block writes it into both levels. A hit in the second level copies only that one page mapping into the first level. Only one lookup is in flight at a time. Each answer is held back until a configurable latency for its hit level has passed, so the block can model the cost of each path. A flush input clears both levels in a single cycle.

Default reach is 16 regions of 128 pages (8 MB) in the first level. The second level defaults to 64 sets of 8 ways so that it stays small in simulation. Its set count is a parameter and can be raised to model a larger reach.

Top module: `tlb2_xlate`

## Requirements
- R1: After reset `req_ready` is 1, `resp_valid` is 0 and `walk_req` is 0.
- R2: A lookup that misses both levels raises `walk_req` with `walk_vpn` equal to the request number, holding both until `walk_valid`. It then answers with `resp_level` = 3 and `resp_ppn` equal to the `walk_ppn` supplied.
- R3: Repeating a lookup of a page that was just translated answers with `resp_level` = 1 and the same physical page number.
- R4: A page whose region already sits in the first level, but whose own page slot has never been filled, does not hit the first level. Once it is translated, that slot hits with level 1, and the region's earlier pages keep hitting with level 1.
- R5: After 16 distinct regions (region = `vpn[19:7]` by default) have each been translated once, a second pass over the same 16 regions hits level 1 on every lookup.
- R6: The first level evicts its least recently used region. Cycling through 17 distinct regions therefore misses the first level on every lookup. With the mappings still held in the second level, each of those lookups answers with `resp_level` = 2.
- R7: The second-level set is `vpn[log2(L2_SETS)-1:0]`. Empty ways fill first, and a full set evicts its pseudo-LRU way. After eight pages fill one set in order, a ninth page in that set evicts the first of them, while the other seven still hit level 2.
- R8: The response appears exactly `LAT_L1` cycles after acceptance for level 1 and exactly `LAT_L2` cycles for level 2. For level 3 it appears no earlier than `LAT_MISS` cycles, and exactly then when the walk returns in time.
- R9: A one-cycle pulse on `flush` invalidates both levels, so the next lookup of a page that was hitting before goes to the walk (level 3).
- R10: Only one lookup is in flight. `req_ready` falls in the cycle after acceptance and stays low up to and including the single cycle in which `resp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate every entry of both levels |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Block is idle and will accept a request |
| req_vpn | input | VPN_W | Virtual page number to translate |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_level | output | 2 | 1 = first level, 2 = second level, 3 = page walk |
| resp_ppn | output | PPN_W | Translated physical page number |
| walk_req | output | 1 | Request to the page-table stand-in |
| walk_vpn | output | VPN_W | Page number the walk must resolve |
| walk_valid | input | 1 | Page-table stand-in answer strobe |
| walk_ppn | input | PPN_W | Physical page number from the stand-in |

## Verification
Lookups are tried in four patterns, and each one separates a different behaviour. Neighbouring pages inside one region show that the region-wide entry tracks each page slot on its own rather than marking the whole region valid. A pass over exactly 16 regions followed by a cyclic sweep over 17 separates true LRU eviction in the first level from any order that would let some region survive. Nine pages driven into one second-level set, after the first level has been emptied by unrelated regions, show which way the pseudo-LRU tree gives up. Every answer is also timed, so that the three latency paths cannot be confused, and a flush between repeated lookups shows that both levels drop their contents.

// File: rtl/tlb2_pkg.sv
package tlb2_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOK,
      ST_WALK,
      ST_WAIT,
      ST_DONE
   } xl_state_e;

   typedef enum logic [1:0] {
      LVL_NONE = 2'd0,
      LVL_L1   = 2'd1,
      LVL_L2   = 2'd2,
      LVL_WALK = 2'd3
   } hit_lvl_e;
endpackage

// File: rtl/tlb2_l1.sv
// Fully-associative region store: one tag per region, one mapping per page slot.
module tlb2_l1 #(
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 20,
   parameter int ENTRIES = 16,
   parameter int PAGES   = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [VPN_W-1:0] vpn,
   output logic             hit,
   output logic [PPN_W-1:0] ppn,
   input  logic             touch,
   input  logic             ins_en,
   input  logic [PPN_W-1:0] ins_ppn
);
   localparam int SW = $clog2(PAGES);
   localparam int EW = $clog2(ENTRIES);
   localparam int TW = VPN_W - SW;

   logic [TW-1:0]    rtag   [ENTRIES];
   logic [PAGES-1:0] sval   [ENTRIES];
   logic [PPN_W-1:0] pmap   [ENTRIES][PAGES];
   logic [EW-1:0]    age    [ENTRIES];
   logic [ENTRIES-1:0] tval;

   logic [TW-1:0]    cur_tag;
   logic [SW-1:0]    cur_slot;
   logic [ENTRIES-1:0] rmatch;
   logic             reg_hit;
   logic [EW-1:0]    hit_idx;
   logic [EW-1:0]    vic_idx;
   logic [EW-1:0]    sel_idx;
   logic             do_ins;
   logic             do_touch;

   assign cur_tag  = vpn[VPN_W-1:SW];
   assign cur_slot = vpn[SW-1:0];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign rmatch[e] = tval[e] && (rtag[e] == cur_tag);
   end

   always_comb begin
      hit_idx = '0;
      for (int e = 0; e < ENTRIES; e++)
         if (rmatch[e]) hit_idx = EW'(e);
   end
   assign reg_hit = |rmatch;
   assign hit     = reg_hit && sval[hit_idx][cur_slot];
   assign ppn     = pmap[hit_idx][cur_slot];

   // victim: lowest empty entry, else the oldest one
   always_comb begin
      vic_idx = '0;
      for (int e = 0; e < ENTRIES; e++)
         if (age[e] == EW'(ENTRIES - 1)) vic_idx = EW'(e);
      for (int e = ENTRIES - 1; e >= 0; e--)
         if (!tval[e]) vic_idx = EW'(e);
   end

   assign sel_idx  = reg_hit ? hit_idx : vic_idx;
   assign do_ins   = ins_en && !flush;
   assign do_touch = (touch || ins_en) && !flush;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tval <= '0;
         for (int e = 0; e < ENTRIES; e++) age[e] <= EW'(e);
      end else if (flush) begin
         tval <= '0;
      end else begin
         if (do_ins) tval[sel_idx] <= 1'b1;
         if (do_touch) begin
            for (int e = 0; e < ENTRIES; e++)
               if (age[e] < age[sel_idx]) age[e] <= age[e] + 1'b1;
            age[sel_idx] <= '0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (do_ins) begin
         if (!reg_hit) begin
            rtag[sel_idx] <= cur_tag;
            sval[sel_idx] <= '0;
         end
         sval[sel_idx][cur_slot] <= 1'b1;
         pmap[sel_idx][cur_slot] <= ins_ppn;
      end
   end
endmodule

// File: rtl/tlb2_l2.sv
// Set-associative page store with a tree pseudo-LRU per set.
module tlb2_l2 #(
   parameter int VPN_W = 20,
   parameter int PPN_W = 20,
   parameter int SETS  = 64,
   parameter int WAYS  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [VPN_W-1:0] vpn,
   output logic             hit,
   output logic [PPN_W-1:0] ppn,
   input  logic             touch,
   input  logic             ins_en,
   input  logic [PPN_W-1:0] ins_ppn
);
   localparam int IW = $clog2(SETS);
   localparam int WW = $clog2(WAYS);
   localparam int TW = VPN_W - IW;

   logic [TW-1:0]    tagm [SETS][WAYS];
   logic [PPN_W-1:0] pm   [SETS][WAYS];
   logic [WAYS-1:0]  vld  [SETS];
   logic [WAYS-2:0]  tree [SETS];

   logic [IW-1:0]    idx;
   logic [TW-1:0]    tg;
   logic [WAYS-1:0]  way_hit;
   logic [WW-1:0]    hit_way;
   logic [WW-1:0]    vic;
   logic [WW-1:0]    way_sel;
   logic             found;
   int               node;

   assign idx = vpn[IW-1:0];
   assign tg  = vpn[VPN_W-1:IW];

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign way_hit[w] = vld[idx][w] && (tagm[idx][w] == tg);
   end

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++)
         if (way_hit[w]) hit_way = WW'(w);
   end
   assign hit = |way_hit;
   assign ppn = pm[idx][hit_way];

   // first empty way, else follow the tree toward the older half
   always_comb begin
      vic   = '0;
      found = 1'b0;
      node  = 1;
      for (int w = 0; w < WAYS; w++)
         if (!found && !vld[idx][w]) begin
            vic   = WW'(w);
            found = 1'b1;
         end
      if (!found) begin
         for (int l = 0; l < WW; l++)
            node = node * 2 + int'(tree[idx][node-1]);
         vic = WW'(node - WAYS);
      end
   end

   function automatic logic [WAYS-2:0] tree_touch(input logic [WAYS-2:0] t,
                                                 input logic [WW-1:0] w);
      logic [WAYS-2:0] r;
      int pos;
      r   = t;
      pos = WAYS + int'(w);
      for (int l = 0; l < WW; l++) begin
         int n;
         int d;
         n = pos >> (WW - l);
         d = (pos >> (WW - l - 1)) & 1;
         r[n-1] = (d == 0);
      end
      return r;
   endfunction

   assign way_sel = ins_en ? vic : hit_way;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            vld[s]  <= '0;
            tree[s] <= '0;
         end
      end else if (flush) begin
         for (int s = 0; s < SETS; s++) vld[s] <= '0;
      end else begin
         if (ins_en) vld[idx][vic] <= 1'b1;
         if (ins_en || touch) tree[idx] <= tree_touch(tree[idx], way_sel);
      end
   end

   always_ff @(posedge clk) begin
      if (ins_en && !flush) begin
         tagm[idx][vic] <= tg;
         pm[idx][vic]   <= ins_ppn;
      end
   end
endmodule

// File: rtl/tlb2_xlate.sv
module tlb2_xlate
   import tlb2_pkg::*;
#(
   parameter int VPN_W      = 20,
   parameter int PPN_W      = 20,
   parameter int L1_ENTRIES = 16,
   parameter int L1_PAGES   = 128,
   parameter int L2_SETS    = 64,
   parameter int L2_WAYS    = 8,
   parameter int LAT_L1     = 440,
   parameter int LAT_L2     = 487,
   parameter int LAT_MISS   = 698
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VPN_W-1:0] req_vpn,
   output logic             resp_valid,
   output logic [1:0]       resp_level,
   output logic [PPN_W-1:0] resp_ppn,
   output logic             walk_req,
   output logic [VPN_W-1:0] walk_vpn,
   input  logic             walk_valid,
   input  logic [PPN_W-1:0] walk_ppn
);
   localparam int LAT_A   = (LAT_L1 > LAT_L2) ? LAT_L1 : LAT_L2;
   localparam int LAT_MAX = (LAT_A > LAT_MISS) ? LAT_A : LAT_MISS;
   localparam int CW      = $clog2(LAT_MAX + 1) + 1;

   if (LAT_L1 < 2 || LAT_L2 < 2 || LAT_MISS < 2) begin : g_bad_lat
      $error("tlb2_xlate: every latency must be at least 2");
   end
   if ((1 << $clog2(L1_ENTRIES)) != L1_ENTRIES || L1_ENTRIES < 2) begin : g_bad_l1e
      $error("tlb2_xlate: L1_ENTRIES must be a power of two >= 2");
   end
   if ((1 << $clog2(L1_PAGES)) != L1_PAGES || L1_PAGES < 2 || $clog2(L1_PAGES) >= VPN_W) begin : g_bad_l1p
      $error("tlb2_xlate: L1_PAGES must be a power of two >= 2 below the page space");
   end
   if ((1 << $clog2(L2_SETS)) != L2_SETS || L2_SETS < 2 || $clog2(L2_SETS) >= VPN_W) begin : g_bad_l2s
      $error("tlb2_xlate: L2_SETS must be a power of two >= 2 below the page space");
   end
   if ((1 << $clog2(L2_WAYS)) != L2_WAYS || L2_WAYS < 2) begin : g_bad_l2w
      $error("tlb2_xlate: L2_WAYS must be a power of two >= 2");
   end

   xl_state_e        state;
   hit_lvl_e         lvl_q;
   logic [CW-1:0]    cnt;
   logic [VPN_W-1:0] vpn_q;
   logic [PPN_W-1:0] ppn_q;

   logic             l1_hit, l2_hit;
   logic [PPN_W-1:0] l1_ppn, l2_ppn;
   logic             l1_touch, l1_ins, l2_touch, l2_ins;
   logic [PPN_W-1:0] fill_ppn;
   logic [CW-1:0]    tgt_m1;

   assign l1_touch = (state == ST_LOOK) && l1_hit;
   assign l2_touch = (state == ST_LOOK) && !l1_hit && l2_hit;
   assign l2_ins   = (state == ST_WALK) && walk_valid;
   assign l1_ins   = l2_touch || l2_ins;
   assign fill_ppn = (state == ST_LOOK) ? l2_ppn : walk_ppn;

   tlb2_l1 #(
      .VPN_W(VPN_W), .PPN_W(PPN_W), .ENTRIES(L1_ENTRIES), .PAGES(L1_PAGES)
   ) u_l1 (
      .clk(clk), .rst_n(rst_n), .flush(flush), .vpn(vpn_q),
      .hit(l1_hit), .ppn(l1_ppn), .touch(l1_touch),
      .ins_en(l1_ins), .ins_ppn(fill_ppn)
   );

   tlb2_l2 #(
      .VPN_W(VPN_W), .PPN_W(PPN_W), .SETS(L2_SETS), .WAYS(L2_WAYS)
   ) u_l2 (
      .clk(clk), .rst_n(rst_n), .flush(flush), .vpn(vpn_q),
      .hit(l2_hit), .ppn(l2_ppn), .touch(l2_touch),
      .ins_en(l2_ins), .ins_ppn(walk_ppn)
   );

   always_comb begin
      unique case (lvl_q)
         LVL_L1:  tgt_m1 = CW'(LAT_L1 - 1);
         LVL_L2:  tgt_m1 = CW'(LAT_L2 - 1);
         default: tgt_m1 = CW'(LAT_MISS - 1);
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         lvl_q <= LVL_NONE;
         cnt   <= '0;
         vpn_q <= '0;
         ppn_q <= '0;
      end else begin
         if (state != ST_IDLE && cnt != '1) cnt <= cnt + 1'b1;
         unique case (state)
            ST_IDLE: if (req_valid) begin
               vpn_q <= req_vpn;
               cnt   <= '0;
               state <= ST_LOOK;
            end
            ST_LOOK: begin
               if (l1_hit) begin
                  lvl_q <= LVL_L1;
                  ppn_q <= l1_ppn;
                  state <= (cnt >= CW'(LAT_L1 - 1)) ? ST_DONE : ST_WAIT;
               end else if (l2_hit) begin
                  lvl_q <= LVL_L2;
                  ppn_q <= l2_ppn;
                  state <= (cnt >= CW'(LAT_L2 - 1)) ? ST_DONE : ST_WAIT;
               end else begin
                  lvl_q <= LVL_WALK;
                  state <= ST_WALK;
               end
            end
            ST_WALK: if (walk_valid) begin
               ppn_q <= walk_ppn;
               state <= (cnt >= CW'(LAT_MISS - 1)) ? ST_DONE : ST_WAIT;
            end
            ST_WAIT: if (cnt >= tgt_m1) state <= ST_DONE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready  = (state == ST_IDLE);
   assign resp_valid = (state == ST_DONE);
   assign resp_level = lvl_q;
   assign resp_ppn   = ppn_q;
   assign walk_req   = (state == ST_WALK);
   assign walk_vpn   = vpn_q;
endmodule

// File: rtl/tlb2_xlate_chk.sv
module tlb2_xlate_chk #(
   parameter int VPN_W    = 20,
   parameter int LAT_L1   = 440,
   parameter int LAT_L2   = 487,
   parameter int LAT_MISS = 698
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic             resp_valid,
   input logic [1:0]       resp_level,
   input logic             walk_req,
   input logic             walk_valid,
   input logic [VPN_W-1:0] walk_vpn
);
   logic [31:0] since_acc;

   always_ff @(posedge clk) begin
      if (!rst_n) since_acc <= 32'hFFFF_FFFF;
      else if (req_valid && req_ready) since_acc <= '0;
      else if (since_acc != 32'hFFFF_FFFF) since_acc <= since_acc + 1;
   end

   AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready); // R10
   AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid); // R10
   AST_RESP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> !req_ready); // R10
   AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_req && !walk_valid) |=> (walk_req && $stable(walk_vpn))); // R2
   AST_WALK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      walk_req |-> !req_ready); // R2
   AST_LEVEL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> (resp_level != 2'd0)); // R2
   AST_L1_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_level == 2'd1) |-> (since_acc == 32'(LAT_L1))); // R8
   AST_L2_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_level == 2'd2) |-> (since_acc == 32'(LAT_L2))); // R8
   AST_MISS_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_level == 2'd3) |-> (since_acc >= 32'(LAT_MISS))); // R8
endmodule

bind tlb2_xlate tlb2_xlate_chk #(
   .VPN_W(VPN_W), .LAT_L1(LAT_L1), .LAT_L2(LAT_L2), .LAT_MISS(LAT_MISS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .resp_valid(resp_valid), .resp_level(resp_level), .walk_req(walk_req),
   .walk_valid(walk_valid), .walk_vpn(walk_vpn)
);

// File: tb/tb_tlb2_xlate.sv
module tb_tlb2_xlate;
   localparam int CLK_PERIOD = 10;
   localparam int VW = 20;
   localparam int PW = 20;
   localparam int T_L1 = 3;
   localparam int T_L2 = 6;
   localparam int T_MISS = 12;

   // {vpn, expected level}: cold page, repeat, neighbour slot, repeats, far page
   localparam int NVEC = 7;
   localparam logic [21:0] VEC [NVEC] = '{
      {20'h00010, 2'd3}, {20'h00010, 2'd1}, {20'h00011, 2'd3}, {20'h00011, 2'd1},
      {20'h00010, 2'd1}, {20'h12345, 2'd3}, {20'h12345, 2'd1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush = 1'b0;
   logic req_valid = 1'b0;
   logic [VW-1:0] req_vpn = '0;
   logic walk_valid = 1'b0;
   logic [PW-1:0] walk_ppn = '0;
   logic req_ready, resp_valid, walk_req;
   logic [1:0] resp_level;
   logic [PW-1:0] resp_ppn;
   logic [VW-1:0] walk_vpn;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   logic [VW-1:0] last_walk_vpn = '0;
   int walks = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tlb2_xlate #(
      .VPN_W(VW), .PPN_W(PW), .L1_ENTRIES(16), .L1_PAGES(128),
      .L2_SETS(16), .L2_WAYS(8), .LAT_L1(T_L1), .LAT_L2(T_L2), .LAT_MISS(T_MISS)
   ) dut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
      .req_ready(req_ready), .req_vpn(req_vpn), .resp_valid(resp_valid),
      .resp_level(resp_level), .resp_ppn(resp_ppn), .walk_req(walk_req),
      .walk_vpn(walk_vpn), .walk_valid(walk_valid), .walk_ppn(walk_ppn)
   );

   function automatic logic [PW-1:0] table_ppn(input logic [VW-1:0] v);
      return v ^ 20'hA5C3F;
   endfunction

   function automatic logic [VW-1:0] rv(input int region, input int low);
      return VW'((region << 7) | low);
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // page-table stand-in: answers two cycles after it sees a request
   initial begin
      forever begin
         @(negedge clk);
         if (walk_req && !walk_valid) begin
            last_walk_vpn = walk_vpn;
            walks++;
            repeat (2) @(negedge clk);
            walk_valid = 1'b1;
            walk_ppn   = table_ppn(last_walk_vpn);
            @(negedge clk);
            walk_valid = 1'b0;
         end
      end
   end

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   end

   task automatic lookup(input logic [VW-1:0] v, input logic [1:0] exp_lvl, input string req);
      int lat;
      bit busy_ok;
      int walks0;
      int exp_lat;
      walks0 = walks;
      @(negedge clk);
      req_valid = 1'b1;
      req_vpn   = v;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      lat = 0;
      busy_ok = 1'b1;
      do begin
         @(posedge clk);
         lat++;
         @(negedge clk);
         if (req_ready) busy_ok = 1'b0;
      end while (!resp_valid && lat < 200);
      exp_lat = (exp_lvl == 2'd1) ? T_L1 : (exp_lvl == 2'd2) ? T_L2 : T_MISS;
      check(resp_level == exp_lvl, req, $sformatf("level vpn=%h", v), resp_level, exp_lvl);
      check(resp_ppn == table_ppn(v), req, $sformatf("ppn vpn=%h", v), resp_ppn, table_ppn(v));
      check(lat == exp_lat, "R8", $sformatf("latency vpn=%h", v), lat, exp_lat);
      check(busy_ok, "R10", "ready held low while busy", busy_ok, 1);
      if (exp_lvl == 2'd3)
         check(walks == walks0 + 1 && last_walk_vpn == v, "R2", "walk vpn",
               last_walk_vpn, v);
   endtask

   task automatic do_flush();
      @(negedge clk);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
      check(resp_valid == 1'b0, "R1", "resp_valid", resp_valid, 0);
      check(walk_req == 1'b0, "R1", "walk_req", walk_req, 0);

      // vector table: R2 (level 3), R3 (level 1)
      for (int i = 0; i < NVEC; i++)
         lookup(VEC[i][21:2], VEC[i][1:0], (VEC[i][1:0] == 2'd3) ? "R2" : "R3");

      // R4: last slot of region 0 is empty although the region is present
      lookup(20'h0007F, 2'd3, "R4");
      lookup(20'h0007F, 2'd1, "R4");
      lookup(20'h00011, 2'd1, "R4");

      // R9: flush drops both levels
      do_flush();
      lookup(20'h00010, 2'd3, "R9");
      lookup(20'h00010, 2'd1, "R9");

      // R5: sixteen regions fit
      do_flush();
      for (int r = 0; r < 16; r++) lookup(rv(r, r & 15), 2'd3, "R5");
      for (int r = 0; r < 16; r++) lookup(rv(r, r & 15), 2'd1, "R5");

      // R6: seventeenth region makes a cyclic sweep miss the first level
      lookup(rv(16, 0), 2'd3, "R6");
      for (int r = 0; r < 17; r++) lookup(rv(r, r & 15), 2'd2, "R6");

      // R7: nine pages into set 5, then push them out of the first level via set 6
      do_flush();
      for (int i = 0; i < 9; i++) lookup(rv(32 + i, 5), 2'd3, "R7");
      for (int r = 64; r < 80; r++) lookup(rv(r, 6), 2'd3, "R7");
      for (int i = 1; i < 9; i++) lookup(rv(32 + i, 5), 2'd2, "R7");
      lookup(rv(32, 5), 2'd3, "R7");

      @(negedge clk);
      check(req_ready == 1'b1 && resp_valid == 1'b0, "R10", "idle after last lookup",
            {req_ready, resp_valid}, 2'b10);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule